// File: doc/BRIEF.md
# Signature Verification Control Sequencer

This block is the top-level controller of a signature-verification engine. A single 8-bit input port serves two roles. While the block is idle it carries control fields: a start strobe, a soft reset and a two-bit mode select. Once an operation has started it carries a stream of bytes, one per clock. A six-bit status word reports the outcome and the progress of the block.

In key-load mode the block shifts a fixed number of public-key bytes into a local key register and then raises a sticky "key ready" flag. In verify mode it takes a packet made of the digest and the two signature halves. It then runs four arithmetic stages in a fixed order: modular inverse of s, the two scalar products, the curve point combination, and the final x-coordinate compare. Each stage gets a one-cycle start strobe and is given a bounded time to answer with a done pulse. The compare stage also returns a match flag, which becomes the accept or reject verdict. The arithmetic units are not part of this block. They connect through the strobe and done ports.

Top module: `sigver_seq`

## Requirements
- R1: The synchronous hard reset (`rst_n` low at a clock edge) clears all six status bits and all stage strobes. The status bit map is: [0] accepted, [1] rejected, [2] busy, [3] stage-done pulse, [4] key ready, [5] packet received.
- R2: In idle, a start is a rising edge on `in_bus[0]` with `in_bus[1]` low. Mode `in_bus[3:2]` = 00 starts a verify and 01 starts a key load. A start with mode 10 or 11 is ignored and leaves the status and strobes unchanged.
- R3: After a key-load start, the next KEY_BYTES cycles each take one byte. The first byte ends up as the most significant byte of `key_word`. Status bit 4 rises after the last byte and stays high until a hard or soft reset. A later key load does not clear it.
- R4: After a verify start with a key present, the next PKT_BYTES cycles each take one byte. The first byte is the most significant byte of `pkt_word`. Status bit 5 rises after the last byte and stays high until the next verify start or a reset.
- R5: A verify start while status bit 4 is low sets status bit 1 at the next edge. It never raises busy and never strobes a stage.
- R6: After the packet, `stage_go` pulses one-hot for exactly one cycle per stage, in the order bit 0 (inverse), bit 1 (scalar), bit 2 (point), bit 3 (compare). A stage's strobe comes only after the previous stage's done. A done that arrives in the same cycle as a strobe is ignored.
- R7: Status bit 3 pulses high for exactly one cycle after each accepted `stage_done`, which gives four pulses for a full verify.
- R8: Busy (bit 2) is high from the edge after a verify start with a key until the edge that posts the verdict, and it is high whenever a strobe is active.
- R9: When the compare stage's done is accepted, bit 0 takes the value of `cmp_match` and bit 1 takes its inverse. The two bits are never high together, and they hold until the next verify start or a reset.
- R10: If no done arrives within WD_CYCLES cycles of a strobe, the block sets bit 1, clears busy and returns to idle.
- R11: `in_bus[1]` high outside byte reception acts as a soft reset. It clears all six status bits and the strobes and returns the block to idle. During byte reception the bit is ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hard reset, active low |
| in_bus | input | 8 | Control fields when idle, data bytes during reception |
| stage_done | input | 1 | Done pulse from the active arithmetic unit |
| cmp_match | input | 1 | Compare result, sampled with the compare stage's done |
| status | output | 6 | Accepted, rejected, busy, stage-done, key ready, packet received |
| stage_go | output | 4 | One-hot, one-cycle start strobe per stage |
| key_word | output | KEY_BYTES*8 | Received public key |
| pkt_word | output | PKT_BYTES*8 | Received packet (digest, r, s) |

## Verification
The bench builds the block with KEY_BYTES=4, PKT_BYTES=6 and WD_CYCLES=16. With these values a complete key load, a packet and the four stages fit in a few dozen cycles, so one run can cover many verify sequences with different done latencies and both match outcomes. The short watchdog window lets the bench drive a stalled stage into a forced reject and check the exact cycle at which it fires. The small byte counts also make it easy to check the full byte order of `key_word` and `pkt_word`.

// File: rtl/sigver_pkg.sv
package sigver_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STG_W      = $clog2(NUM_STAGES);

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RXKEY = 2'd1,
    SQ_RXPKT = 2'd2,
    SQ_WAIT  = 2'd3
  } sq_state_t;

  localparam logic [1:0] MODE_VERIFY = 2'b00;
  localparam logic [1:0] MODE_KEY    = 2'b01;
endpackage

// File: rtl/sv_byte_shift.sv
module sv_byte_shift #(
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  shift_en,
  input  logic [7:0]            byte_in,
  output logic                  last,
  output logic [NBYTES*8-1:0]   word
);
  localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [CW-1:0] cnt;

  assign last = shift_en && (cnt == CW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      word <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (shift_en) begin
      word <= {word[NBYTES*8-9:0], byte_in};
      cnt  <= last ? '0 : cnt + CW'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NBYTES - 1)); // R3
endmodule

// File: rtl/sv_stage_timer.sv
module sv_stage_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = run && !restart && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (run && !expired)
      cnt <= cnt + CW'(1);
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1)); // R10
endmodule

// File: rtl/sigver_seq.sv
module sigver_seq
  import sigver_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter int PKT_BYTES = 12,
  parameter int WD_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              in_bus,
  input  logic                    stage_done,
  input  logic                    cmp_match,
  output logic [5:0]              status,
  output logic [NUM_STAGES-1:0]   stage_go,
  output logic [KEY_BYTES*8-1:0]  key_word,
  output logic [PKT_BYTES*8-1:0]  pkt_word
);
  sq_state_t            state;
  logic                 prev0;
  logic [STG_W-1:0]     stg;
  logic [NUM_STAGES-1:0] go_q;
  logic valid_q, reject_q, busy_q, eccd_q, keyok_q, pktok_q;

  logic srst, start_edge, go_key, go_ver, done_ok, issue_go, wd_exp;
  logic key_last, pkt_last, last_stage;

  assign srst       = in_bus[1] && (state != SQ_RXKEY) && (state != SQ_RXPKT);
  assign start_edge = (state == SQ_IDLE) && in_bus[0] && !prev0 && !in_bus[1];
  assign go_key     = start_edge && (in_bus[3:2] == MODE_KEY);
  assign go_ver     = start_edge && (in_bus[3:2] == MODE_VERIFY);
  assign done_ok    = (state == SQ_WAIT) && stage_done && (go_q == '0);
  assign last_stage = (stg == STG_W'(NUM_STAGES - 1));
  assign issue_go   = !srst && (pkt_last || (done_ok && !last_stage));

  sv_byte_shift #(.NBYTES(KEY_BYTES)) u_key (
    .clk(clk), .rst_n(rst_n), .restart(go_key),
    .shift_en(state == SQ_RXKEY), .byte_in(in_bus),
    .last(key_last), .word(key_word)
  );

  sv_byte_shift #(.NBYTES(PKT_BYTES)) u_pkt (
    .clk(clk), .rst_n(rst_n), .restart(go_ver),
    .shift_en(state == SQ_RXPKT), .byte_in(in_bus),
    .last(pkt_last), .word(pkt_word)
  );

  sv_stage_timer #(.LIMIT(WD_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .restart(issue_go),
    .run(state == SQ_WAIT), .expired(wd_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      prev0    <= 1'b0;
      stg      <= '0;
      go_q     <= '0;
      valid_q  <= 1'b0;
      reject_q <= 1'b0;
      busy_q   <= 1'b0;
      eccd_q   <= 1'b0;
      keyok_q  <= 1'b0;
      pktok_q  <= 1'b0;
    end else begin
      prev0  <= in_bus[0];
      go_q   <= '0;
      eccd_q <= 1'b0;
      if (srst) begin
        state    <= SQ_IDLE;
        valid_q  <= 1'b0;
        reject_q <= 1'b0;
        busy_q   <= 1'b0;
        keyok_q  <= 1'b0;
        pktok_q  <= 1'b0;
      end else begin
        case (state)
          SQ_IDLE: begin
            if (go_key) begin
              state <= SQ_RXKEY;
            end else if (go_ver) begin
              valid_q <= 1'b0;
              pktok_q <= 1'b0;
              if (keyok_q) begin
                reject_q <= 1'b0;
                busy_q   <= 1'b1;
                state    <= SQ_RXPKT;
              end else begin
                reject_q <= 1'b1;
              end
            end
          end
          SQ_RXKEY: begin
            if (key_last) begin
              keyok_q <= 1'b1;
              state   <= SQ_IDLE;
            end
          end
          SQ_RXPKT: begin
            if (pkt_last) begin
              pktok_q <= 1'b1;
              stg     <= '0;
              go_q    <= NUM_STAGES'(1);
              state   <= SQ_WAIT;
            end
          end
          SQ_WAIT: begin
            if (done_ok) begin
              eccd_q <= 1'b1;
              if (last_stage) begin
                valid_q  <= cmp_match;
                reject_q <= !cmp_match;
                busy_q   <= 1'b0;
                state    <= SQ_IDLE;
              end else begin
                stg  <= stg + STG_W'(1);
                go_q <= NUM_STAGES'(1) << (stg + STG_W'(1));
              end
            end else if (wd_exp) begin
              reject_q <= 1'b1;
              busy_q   <= 1'b0;
              state    <= SQ_IDLE;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  assign status   = {pktok_q, keyok_q, eccd_q, busy_q, reject_q, valid_q};
  assign stage_go = go_q;

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && reject_q)); // R9
  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_q)); // R6
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q != '0) |=> (go_q == '0)); // R6
  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q != '0) |-> busy_q); // R8
  AST_ECC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eccd_q |=> !eccd_q); // R7
  AST_KEY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (keyok_q && !srst) |=> keyok_q); // R3
  AST_PKT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RXPKT) |-> keyok_q); // R5
  AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status == 6'd0 && stage_go == '0)); // R11
endmodule

// File: tb/sigver_seq_bench.sv
module sigver_seq_bench;
  localparam int KB = 4;
  localparam int PB = 6;
  localparam int WD = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      in_bus = 8'h00;
  logic            stage_done = 1'b0;
  logic            cmp_match = 1'b0;
  logic [5:0]      status;
  logic [3:0]      stage_go;
  logic [KB*8-1:0] key_word;
  logic [PB*8-1:0] pkt_word;

  int n_chk = 0;
  int n_bad = 0;

  // vector: bit7 = compare match, [3:0] = done latency in cycles
  localparam logic [7:0] VEC [4] = '{8'h81, 8'h03, 8'h85, 8'h02};

  always #4 clk = ~clk;

  sigver_seq #(.KEY_BYTES(KB), .PKT_BYTES(PB), .WD_CYCLES(WD)) u_sigver_seq (
    .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .stage_done(stage_done),
    .cmp_match(cmp_match), .status(status), .stage_go(stage_go),
    .key_word(key_word), .pkt_word(pkt_word)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse_start(input logic [1:0] mode);
    @(negedge clk);
    in_bus = {4'h0, mode, 2'b01};
  endtask

  task automatic load_key(input logic [7:0] base);
    logic [KB*8-1:0] exp = '0;
    pulse_start(2'b01);
    for (int i = 0; i < KB; i++) begin
      @(negedge clk);
      in_bus = base + 8'(i * 17);
      exp = {exp[KB*8-9:0], in_bus};
    end
    @(negedge clk);
    in_bus = 8'h00;
    chk("R3 key ready", 64'(status[4]), 64'd1);
    chk("R3 key order", 64'(key_word), 64'(exp));
  endtask

  // Sends a packet and answers stages; returns at the strobe of stage 'drop'.
  task automatic run_verify(input logic m, input int lat, input int drop, input logic [7:0] base);
    logic [PB*8-1:0] exp = '0;
    int n_ecc = 0;
    pulse_start(2'b00);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      if (i == 0) chk("R8 busy after start", 64'(status[2]), 64'd1);
      in_bus = base + 8'(i);
      exp = {exp[PB*8-9:0], in_bus};
    end
    @(negedge clk);
    in_bus = 8'h00;
    chk("R4 packet received", 64'(status[5]), 64'd1);
    chk("R4 packet order", 64'(pkt_word), 64'(exp));
    for (int k = 0; k < 4; k++) begin
      int w = 0;
      while (stage_go == 4'd0 && w < 20) begin
        @(negedge clk);
        w++;
      end
      chk("R6 stage order", 64'(stage_go), 64'(4'd1 << k));
      chk("R8 busy with strobe", 64'(status[2]), 64'd1);
      if (k == drop) return;
      for (int d = 0; d < lat; d++) @(negedge clk);
      stage_done = 1'b1;
      cmp_match = m;
      @(negedge clk);
      stage_done = 1'b0;
      if (status[3]) n_ecc++;
      if (k < 3) chk("R7 pulse ends", 64'(stage_go != 4'd0 || status[3] == 1'b1), 64'd1);
    end
    chk("R7 four stage pulses", 64'(n_ecc), 64'd4);
    chk("R9 accept bit", 64'(status[0]), 64'(m));
    chk("R9 reject bit", 64'(status[1]), 64'(!m));
    chk("R8 busy low at verdict", 64'(status[2]), 64'd0);
    @(negedge clk);
    chk("R7 single cycle pulse", 64'(status[3]), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [5:0] snap;
    repeat (3) @(negedge clk);
    chk("R1 reset status", 64'(status), 64'd0);
    chk("R1 reset strobes", 64'(stage_go), 64'd0);
    rst_n = 1'b1;

    // R5: verify with no key
    pulse_start(2'b00);
    @(negedge clk);
    in_bus = 8'h00;
    chk("R5 reject without key", 64'(status), 64'h02);
    repeat (4) @(negedge clk);
    chk("R5 no strobe", 64'(stage_go), 64'd0);
    chk("R5 busy stays low", 64'(status[2]), 64'd0);

    // R3, R11: key bytes include bit1 set (data, not soft reset)
    load_key(8'hA1);

    // R2: ignored modes
    snap = status;
    pulse_start(2'b10);
    @(negedge clk); in_bus = 8'h00;
    repeat (3) @(negedge clk);
    chk("R2 mode 10 ignored", 64'(status), 64'(snap));
    pulse_start(2'b11);
    @(negedge clk); in_bus = 8'h00;
    repeat (3) @(negedge clk);
    chk("R2 mode 11 ignored", 64'(status), 64'(snap));
    chk("R2 no strobe", 64'(stage_go), 64'd0);

    // vector table
    for (int v = 0; v < 4; v++) begin
      run_verify(VEC[v][7], int'(VEC[v][3:0]), 9, 8'(v * 16 + 1));
      repeat (3) @(negedge clk);
      chk("R9 verdict held", 64'(status[1:0]), 64'(VEC[v][7] ? 2'b01 : 2'b10));
    end

    // R10: stalled point stage
    begin
      int w = 0;
      run_verify(1'b1, 1, 2, 8'h40);
      while (status[2] && w < 40) begin
        @(negedge clk);
        w++;
      end
      chk("R10 timeout cycles", 64'(w), 64'(WD));
      chk("R10 forced reject", 64'(status[1:0]), 64'b10);
      chk("R3 key still ready", 64'(status[4]), 64'd1);
    end

    // R11: soft reset during a stage wait
    run_verify(1'b1, 1, 1, 8'h70);
    @(negedge clk);
    in_bus = 8'h02;
    @(negedge clk);
    in_bus = 8'h00;
    chk("R11 soft reset clears status", 64'(status), 64'd0);
    chk("R11 soft reset clears strobes", 64'(stage_go), 64'd0);
    pulse_start(2'b00);
    @(negedge clk);
    in_bus = 8'h00;
    chk("R5 reject after key cleared", 64'(status[2:0]), 64'b010);

    // R1: hard reset after activity
    load_key(8'h13);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 hard reset clears", 64'(status), 64'd0);
    rst_n = 1'b1;
    report();
  end
endmodule